// File: doc/BRIEF.md
# Tag Ring Slave Node

This block sits at one node of a unidirectional tag ring. Each heartbeat delivers a 64-bit tag. The block registers that tag and sends it downstream one clock later, changed where the protocol requires it. A 2-bit class field decides how the node treats the tag:

- Filler tags and scheduler-bound messages pass through untouched.
- Free consumable slots can be taken over to report a local error or a throttle request.
- Valid consumable tags are meant for the slaves.

Tags meant for this node go into a small queue. These are broadcast commands, broadcast messages, and messages carrying this node's ID. An executor drains the queue:

- A command loads a DMA engine with a buffer address and a destination CPU ID. All nodes on the ring see the same command, so every engine gets an identical load.
- Messages produce flush pulses, diagnostic pulses or a new operating mode.

Every command the node executes increments a hop counter inside the tag. The node raises the tag's completion flag when the counter reaches the ring population. The scheduler can therefore tell that every slave has seen the command.

Top module: `tag_ring_slave`

Tag bit layout (MSB first):

| Bits | Field |
|---|---|
| [63:62] | class |
| [61:60] | type |
| [59:57] | op code |
| [56] | first |
| [55] | force |
| [54] | completion flag |
| [53:51] | spare |
| [50:39] | ID / data |
| [38:28] | buffer address |
| [27:21] | hop count |
| [20:14] | origin |
| [13:7] | info |
| [6:0] | check bits |

Class encoding: 00 filler, 01 free slot, 10 scheduler-bound, 11 for slaves.

Type encoding within class 11: 00 command, 01 broadcast message, 10 addressed message.

## Requirements
- R1: Every `tag_in_valid` cycle yields exactly one `tag_out_valid` cycle on the next clock. After reset `tag_out_valid`, `dma_load`, `flush_pulse` and `diag_pulse` are 0 and `op_mode` is 0.
- R2: A class 00 tag is forwarded bit-for-bit and has no effect on DMA, flush, diagnostic or mode outputs.
- R3: A class 10 tag is forwarded bit-for-bit and triggers nothing.
- R4: A class 01 tag is forwarded bit-for-bit when no error or throttle report is pending.
- R5: A command tag (class 11, type 00) that is queued produces one `dma_load` pulse. The pulse carries the tag's buffer address on `dma_buf_addr` and its ID field on `dma_cpu_id`. It appears two clocks after the tag is sampled when `dma_ready` is high.
- R6: A queued command tag is forwarded with its hop count incremented by one (modulo 128). The completion flag is set when the new count equals `ring_size`, and any flag already set is kept. No other field changes.
- R7: An addressed message (class 11, type 10) whose ID differs from `node_id` is forwarded unchanged and has no effect.
- R8: Three queued messages take effect on the executor cycle:
  - an addressed message with op code 000 loads `op_mode` from info[5:0];
  - an addressed or broadcast message with op code 001 pulses `flush_pulse`;
  - a broadcast message with op code 000 pulses `diag_pulse`.
- R9: A pending error (set by `err_raise`, code latched from `err_code`) replaces the next class 01 tag. The replacement carries:
  - class 10, type 11, op code 100;
  - ID = `node_id` and origin = `node_id[6:0]`;
  - info = the error code;
  - all other bits 0.

  The injection clears the pending error. An `err_raise` in the same cycle as an injection remains pending with its new code, while the injected tag carries the old code.
- R10: A pending throttle request (`throttle_raise`) replaces a class 01 tag in the same way as R9, but with op code 001 and info 0. A pending error has priority over a pending throttle request.
- R11: Commands wait while `dma_ready` is low. The queue holds `QDEPTH` tags. A tag for this node that arrives while the queue is full is forwarded unchanged and not executed. Queued commands load the DMA engine in arrival order once `dma_ready` rises, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 12 | This node's address |
| ring_size | input | 7 | Number of slaves on the ring |
| tag_in_valid | input | 1 | A tag is present on tag_in |
| tag_in | input | 64 | Incoming tag |
| tag_out_valid | output | 1 | A tag is present on tag_out |
| tag_out | output | 64 | Forwarded tag |
| err_raise | input | 1 | Report a local error |
| err_code | input | 7 | Error code for err_raise |
| throttle_raise | input | 1 | Request a throttle report |
| dma_ready | input | 1 | DMA engine can take a load |
| dma_load | output | 1 | One-cycle DMA load strobe |
| dma_buf_addr | output | 11 | Source buffer address |
| dma_cpu_id | output | 12 | Destination CPU ID |
| flush_pulse | output | 1 | Flush buffers and reset pointers |
| diag_pulse | output | 1 | Diagnostic request |
| op_mode | output | 6 | Selected operating mode |

## Verification
Two things can land in one clock: injection of an already pending error into a free slot, and a fresh `err_raise`. The bench raises a first error, then presents a class 01 tag in the same cycle it pulses `err_raise` with a different code. The forwarded tag must carry the first code. The next free slot must carry the second, and a third slot must pass unchanged. A second coincidence is a command arriving while the queue is full: its hop count must stay unchanged and it must not produce a DMA load.

// File: rtl/tag_ring_pkg.sv
package tag_ring_pkg;

    typedef struct packed {
        logic [1:0]  cls;
        logic [1:0]  typ;
        logic [2:0]  op;
        logic        first;
        logic        frc;
        logic        done;
        logic [2:0]  spare;
        logic [11:0] id;
        logic [10:0] buf_adr;
        logic [6:0]  hops;
        logic [6:0]  origin;
        logic [6:0]  info;
        logic [6:0]  chk;
    } tag_t;

    localparam logic [1:0] CLS_FILL  = 2'b00;
    localparam logic [1:0] CLS_FREE  = 2'b01;
    localparam logic [1:0] CLS_SCHED = 2'b10;
    localparam logic [1:0] CLS_SLAVE = 2'b11;

    localparam logic [1:0] TYP_CMD   = 2'b00;
    localparam logic [1:0] TYP_BCAST = 2'b01;
    localparam logic [1:0] TYP_ADDR  = 2'b10;
    localparam logic [1:0] TYP_UP    = 2'b11;

    localparam logic [2:0] OP_MODE   = 3'b000;
    localparam logic [2:0] OP_DIAG   = 3'b000;
    localparam logic [2:0] OP_FLUSH  = 3'b001;
    localparam logic [2:0] OP_THROT  = 3'b001;
    localparam logic [2:0] OP_ERROR  = 3'b100;

    function automatic tag_t make_report(input logic [2:0] op,
                                         input logic [11:0] nid,
                                         input logic [6:0] info);
        tag_t t;
        t        = '0;
        t.cls    = CLS_SCHED;
        t.typ    = TYP_UP;
        t.op     = op;
        t.id     = nid;
        t.origin = nid[6:0];
        t.info   = info;
        return t;
    endfunction

endpackage

// File: rtl/tag_queue.sv
module tag_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } qstate_t;

    qstate_t q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == (AW+1)'(DEPTH));
    assign dout  = mem_q[q_q.rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (push && !full) q_d.wp = nxt(q_q.wp);
        if (pop && !empty) q_d.rp = nxt(q_q.rp);
        q_d.cnt = q_q.cnt + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem_q[q_q.wp] <= din;
    end

endmodule

// File: rtl/tag_forward.sv
module tag_forward
    import tag_ring_pkg::*;
(
    input  logic        vld,
    input  tag_t        tin,
    input  logic        room,
    input  logic [11:0] node_id,
    input  logic [6:0]  ring_size,
    input  logic        err_pend,
    input  logic [6:0]  err_code,
    input  logic        thr_pend,
    output logic        for_me,
    output tag_t        tout,
    output logic        inj_err,
    output logic        inj_thr
);
    logic is_cmd;
    logic [6:0] hops_inc;

    always_comb begin
        is_cmd   = (tin.cls == CLS_SLAVE) && (tin.typ == TYP_CMD);
        for_me   = (tin.cls == CLS_SLAVE) &&
                   ((tin.typ == TYP_CMD) || (tin.typ == TYP_BCAST) ||
                    ((tin.typ == TYP_ADDR) && (tin.id == node_id)));
        hops_inc = tin.hops + 7'd1;
        inj_err  = vld && (tin.cls == CLS_FREE) && err_pend;
        inj_thr  = vld && (tin.cls == CLS_FREE) && !err_pend && thr_pend;
        tout     = tin;
        if (inj_err) begin
            tout = make_report(OP_ERROR, node_id, err_code);
        end else if (inj_thr) begin
            tout = make_report(OP_THROT, node_id, 7'd0);
        end else if (is_cmd && room) begin
            tout.hops = hops_inc;
            tout.done = tin.done | (hops_inc == ring_size);
        end
    end

endmodule

// File: rtl/tag_ring_slave.sv
module tag_ring_slave
    import tag_ring_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] node_id,
    input  logic [6:0]  ring_size,
    input  logic        tag_in_valid,
    input  logic [63:0] tag_in,
    output logic        tag_out_valid,
    output logic [63:0] tag_out,
    input  logic        err_raise,
    input  logic [6:0]  err_code,
    input  logic        throttle_raise,
    input  logic        dma_ready,
    output logic        dma_load,
    output logic [10:0] dma_buf_addr,
    output logic [11:0] dma_cpu_id,
    output logic        flush_pulse,
    output logic        diag_pulse,
    output logic [5:0]  op_mode
);
    typedef struct packed {
        tag_t        tag;
        logic        tag_vld;
        logic        err_pend;
        logic [6:0]  err_code;
        logic        thr_pend;
        logic        load;
        logic [10:0] buf_adr;
        logic [11:0] cpu;
        logic        flush;
        logic        diag;
        logic [5:0]  mode;
    } st_t;

    st_t  st_q, st_d;
    tag_t tin, fwd, head;
    logic for_me, inj_err, inj_thr;
    logic q_push, q_pop, q_empty, q_full;
    logic [63:0] q_dout;

    assign tin  = tag_t'(tag_in);
    assign head = tag_t'(q_dout);

    tag_forward u_fwd (
        .vld       (tag_in_valid),
        .tin       (tin),
        .room      (!q_full),
        .node_id   (node_id),
        .ring_size (ring_size),
        .err_pend  (st_q.err_pend),
        .err_code  (st_q.err_code),
        .thr_pend  (st_q.thr_pend),
        .for_me    (for_me),
        .tout      (fwd),
        .inj_err   (inj_err),
        .inj_thr   (inj_thr)
    );

    assign q_push = tag_in_valid && for_me && !q_full;

    tag_queue #(.DEPTH(QDEPTH), .W(64)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (tag_in),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tag_vld = 1'b0;
        st_d.load    = 1'b0;
        st_d.flush   = 1'b0;
        st_d.diag    = 1'b0;
        q_pop        = 1'b0;

        if (tag_in_valid) begin
            st_d.tag     = fwd;
            st_d.tag_vld = 1'b1;
        end
        if (inj_err) st_d.err_pend = 1'b0;
        if (inj_thr) st_d.thr_pend = 1'b0;
        if (err_raise) begin
            st_d.err_pend = 1'b1;
            st_d.err_code = err_code;
        end
        if (throttle_raise) st_d.thr_pend = 1'b1;

        if (!q_empty) begin
            if (head.typ == TYP_CMD) begin
                if (dma_ready) begin
                    q_pop        = 1'b1;
                    st_d.load    = 1'b1;
                    st_d.buf_adr = head.buf_adr;
                    st_d.cpu     = head.id;
                end
            end else begin
                q_pop = 1'b1;
                if (head.op == OP_FLUSH) st_d.flush = 1'b1;
                if (head.typ == TYP_ADDR && head.op == OP_MODE) st_d.mode = head.info[5:0];
                if (head.typ == TYP_BCAST && head.op == OP_DIAG) st_d.diag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_out_valid = st_q.tag_vld;
    assign tag_out       = st_q.tag;
    assign dma_load      = st_q.load;
    assign dma_buf_addr  = st_q.buf_adr;
    assign dma_cpu_id    = st_q.cpu;
    assign flush_pulse   = st_q.flush;
    assign diag_pulse    = st_q.diag;
    assign op_mode       = st_q.mode;

endmodule

// File: rtl/tag_ring_slave_chk.sv
module tag_ring_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tag_in_valid,
    input logic [63:0] tag_in,
    input logic        tag_out_valid,
    input logic [63:0] tag_out,
    input logic        dma_ready,
    input logic        dma_load,
    input logic        err_raise
);
    AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        tag_in_valid |=> tag_out_valid) else $error("one out per in"); // R1
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_in_valid |=> !tag_out_valid) else $error("spurious out"); // R1
    AST_FILLER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_in_valid && tag_in[63:62] == 2'b00) |=> (tag_out == $past(tag_in)))
        else $error("filler changed"); // R2
    AST_SCHED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_in_valid && tag_in[63:62] == 2'b10) |=> (tag_out == $past(tag_in)))
        else $error("sched msg changed"); // R3
    AST_CMD_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_in_valid && tag_in[63:60] == 4'b1100) |=>
        ((tag_out[27:21] == 7'($past(tag_in[27:21]) + 7'd1)) || (tag_out == $past(tag_in))))
        else $error("hop count step"); // R6
    AST_LOAD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_load |-> $past(dma_ready)) else $error("load without ready"); // R11
endmodule

bind tag_ring_slave tag_ring_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tag_in_valid  (tag_in_valid),
    .tag_in        (tag_in),
    .tag_out_valid (tag_out_valid),
    .tag_out       (tag_out),
    .dma_ready     (dma_ready),
    .dma_load      (dma_load),
    .err_raise     (err_raise)
);

// File: tb/sim_tag_ring_slave.sv
module sim_tag_ring_slave;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] node_id;
    logic [6:0]  ring_size;
    logic        tag_in_valid;
    logic [63:0] tag_in;
    logic        tag_out_valid;
    logic [63:0] tag_out;
    logic        err_raise;
    logic [6:0]  err_code;
    logic        throttle_raise;
    logic        dma_ready;
    logic        dma_load;
    logic [10:0] dma_buf_addr;
    logic [11:0] dma_cpu_id;
    logic        flush_pulse;
    logic        diag_pulse;
    logic [5:0]  op_mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tag_ring_slave #(.QDEPTH(4)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [1:0] c, input logic [1:0] t, input logic [2:0] op,
                                       input logic [2:0] flg, input logic [11:0] id, input logic [10:0] ba,
                                       input logic [6:0] hops, input logic [6:0] org, input logic [6:0] info,
                                       input logic [6:0] ck);
        return {c, t, op, flg, 3'b000, id, ba, hops, org, info, ck};
    endfunction

    function automatic logic [63:0] rpt(input logic [2:0] op, input logic [6:0] info);
        return mk(2'b10, 2'b11, op, 3'b000, node_id, 11'd0, 7'd0, node_id[6:0], info, 7'd0);
    endfunction

    logic [63:0] got;
    logic        gv;

    task automatic send(input logic [63:0] t, input logic er, input logic thr);
        @(negedge clk);
        tag_in = t; tag_in_valid = 1'b1; err_raise = er; throttle_raise = thr;
        @(negedge clk);
        tag_in_valid = 1'b0; err_raise = 1'b0; throttle_raise = 1'b0;
        got = tag_out; gv = tag_out_valid;
    endtask

    task automatic t_reset();
        chk("R1 reset out_valid", 64'(tag_out_valid), 64'd0);
        chk("R1 reset dma_load", 64'(dma_load), 64'd0);
        chk("R1 reset mode", 64'(op_mode), 64'd0);
        chk("R1 reset pulses", 64'({flush_pulse, diag_pulse}), 64'd0);
    endtask

    task automatic t_passthrough();
        logic [63:0] t;
        t = mk(2'b00, 2'b10, 3'b001, 3'b101, node_id, 11'h155, 7'd9, 7'd3, 7'd5, 7'h2a);
        send(t, 1'b0, 1'b0);
        chk("R1 out valid", 64'(gv), 64'd1);
        chk("R2 filler unchanged", got, t);
        @(negedge clk);
        chk("R2 filler no effect", 64'({dma_load, flush_pulse, diag_pulse}), 64'd0);
        chk("R1 single out", 64'(tag_out_valid), 64'd0);
        t = mk(2'b10, 2'b00, 3'b001, 3'b000, 12'h0aa, 11'h10, 7'd1, 7'd2, 7'd3, 7'h11);
        send(t, 1'b0, 1'b0);
        chk("R3 sched unchanged", got, t);
        @(negedge clk);
        chk("R3 sched no effect", 64'({dma_load, flush_pulse, diag_pulse}), 64'd0);
        t = mk(2'b01, 2'b01, 3'b010, 3'b000, 12'h123, 11'h7, 7'd0, 7'd0, 7'd0, 7'h33);
        send(t, 1'b0, 1'b0);
        chk("R4 free slot unchanged", got, t);
    endtask

    task automatic t_command();
        logic [63:0] t;
        t = mk(2'b11, 2'b00, 3'b000, 3'b000, 12'hc3e, 11'h5a1, 7'd3, 7'd0, 7'd0, 7'h05);
        send(t, 1'b0, 1'b0);
        chk("R6 count +1", got, mk(2'b11, 2'b00, 3'b000, 3'b000, 12'hc3e, 11'h5a1, 7'd4, 7'd0, 7'd0, 7'h05));
        chk("R5 no load yet", 64'(dma_load), 64'd0);
        @(negedge clk);
        chk("R5 load strobe", 64'(dma_load), 64'd1);
        chk("R5 buf addr", 64'(dma_buf_addr), 64'h5a1);
        chk("R5 cpu id", 64'(dma_cpu_id), 64'hc3e);
        @(negedge clk);
        chk("R5 single strobe", 64'(dma_load), 64'd0);
        t = mk(2'b11, 2'b00, 3'b000, 3'b000, 12'h001, 11'h002, 7'd7, 7'd0, 7'd0, 7'h00);
        send(t, 1'b0, 1'b0);
        chk("R6 done at ring size", got, mk(2'b11, 2'b00, 3'b000, 3'b001, 12'h001, 11'h002, 7'd8, 7'd0, 7'd0, 7'h00));
        @(negedge clk);
        t = mk(2'b11, 2'b00, 3'b000, 3'b000, 12'h001, 11'h003, 7'd127, 7'd0, 7'd0, 7'h00);
        send(t, 1'b0, 1'b0);
        chk("R6 count wraps", got, mk(2'b11, 2'b00, 3'b000, 3'b000, 12'h001, 11'h003, 7'd0, 7'd0, 7'd0, 7'h00));
        @(negedge clk);
    endtask

    task automatic t_messages();
        logic [63:0] t;
        t = mk(2'b11, 2'b10, 3'b000, 3'b000, node_id + 12'd1, 11'd0, 7'd0, 7'd0, 7'h15, 7'd0);
        send(t, 1'b0, 1'b0);
        chk("R7 other id unchanged", got, t);
        @(negedge clk); @(negedge clk);
        chk("R7 other id no mode", 64'(op_mode), 64'd0);
        t = mk(2'b11, 2'b10, 3'b000, 3'b000, node_id, 11'd0, 7'd0, 7'd0, 7'h2b, 7'd0);
        send(t, 1'b0, 1'b0);
        chk("R8 mode msg forwarded", got, t);
        @(negedge clk);
        chk("R8 mode loaded", 64'(op_mode), 64'h2b);
        chk("R8 mode no load", 64'(dma_load), 64'd0);
        t = mk(2'b11, 2'b10, 3'b001, 3'b000, node_id, 11'd0, 7'd0, 7'd0, 7'd0, 7'd0);
        send(t, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 directed flush", 64'({flush_pulse, diag_pulse}), 64'b10);
        t = mk(2'b11, 2'b01, 3'b000, 3'b000, 12'h999, 11'd0, 7'd0, 7'd0, 7'd0, 7'd0);
        send(t, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 diag", 64'({flush_pulse, diag_pulse}), 64'b01);
        chk("R8 mode kept", 64'(op_mode), 64'h2b);
    endtask

    task automatic t_reports();
        logic [63:0] fr;
        fr = mk(2'b01, 2'b00, 3'b000, 3'b000, 12'h0, 11'h0, 7'd0, 7'd0, 7'd0, 7'h44);
        err_code = 7'h31;
        send(mk(2'b00, 2'b00, 3'b0, 3'b0, 12'h0, 11'h0, 7'd0, 7'd0, 7'd0, 7'd0), 1'b1, 1'b0);
        send(fr, 1'b0, 1'b0);
        chk("R9 error injected", got, rpt(3'b100, 7'h31));
        send(fr, 1'b0, 1'b0);
        chk("R9 pending cleared", got, fr);
        err_code = 7'h0c;
        send(mk(2'b00, 2'b00, 3'b0, 3'b0, 12'h0, 11'h0, 7'd0, 7'd0, 7'd0, 7'd0), 1'b1, 1'b0);
        err_code = 7'h52;
        send(fr, 1'b1, 1'b0);
        chk("R9 collision old code", got, rpt(3'b100, 7'h0c));
        send(fr, 1'b0, 1'b0);
        chk("R9 collision new code kept", got, rpt(3'b100, 7'h52));
        send(fr, 1'b0, 1'b0);
        chk("R9 collision cleared", got, fr);
        send(fr, 1'b0, 1'b1);
        send(fr, 1'b0, 1'b0);
        chk("R10 throttle injected", got, rpt(3'b001, 7'd0));
        err_code = 7'h07;
        send(mk(2'b00, 2'b00, 3'b0, 3'b0, 12'h0, 11'h0, 7'd0, 7'd0, 7'd0, 7'd0), 1'b1, 1'b1);
        send(fr, 1'b0, 1'b0);
        chk("R10 error first", got, rpt(3'b100, 7'h07));
        send(fr, 1'b0, 1'b0);
        chk("R10 throttle second", got, rpt(3'b001, 7'd0));
    endtask

    task automatic t_backpressure();
        logic [63:0] t;
        dma_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            t = mk(2'b11, 2'b00, 3'b000, 3'b000, 12'h100 + 12'(i), 11'h40 + 11'(i), 7'd1, 7'd0, 7'd0, 7'd0);
            send(t, 1'b0, 1'b0);
            chk("R11 queued cmd counted", 64'(got[27:21]), 64'd2);
        end
        t = mk(2'b11, 2'b00, 3'b000, 3'b000, 12'h1ff, 11'h7ff, 7'd1, 7'd0, 7'd0, 7'd0);
        send(t, 1'b0, 1'b0);
        chk("R11 full cmd unchanged", got, t);
        @(negedge clk);
        chk("R11 held while not ready", 64'(dma_load), 64'd0);
        dma_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 drain strobe", 64'(dma_load), 64'd1);
            chk("R11 drain order", 64'(dma_buf_addr), 64'(11'h40 + 11'(i)));
        end
        @(negedge clk);
        chk("R11 dropped cmd not run", 64'(dma_load), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; node_id = 12'h2d7; ring_size = 7'd8;
        tag_in_valid = 1'b0; tag_in = '0; err_raise = 1'b0; err_code = '0;
        throttle_raise = 1'b0; dma_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_command();
        t_messages();
        t_reports();
        t_backpressure();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule